// File: doc/BRIEF.md
# Cache Control and Monitor Counters

This block is the control and statistics slice of a flash cache. It does two jobs. The first starts on a one-cycle invalidate strobe: a sequencer then walks every cache line in turn, one per cycle, and presents each line index on a clear port that the tag store uses to drop that line's valid bit. The second job is a ready flag. It tells software that the cache is enabled and that no sweep is in progress.

The block also holds eight saturating event counters. Four count data-side events and four count instruction-side events. The cache hit/miss logic feeds them single-cycle pulses. The counters advance only while the monitor-enable input is high. When that input is low they hold their values. They return to zero only when a statistics-clear strobe arrives.

All pins are plain control or status signals. The clear port has no back-pressure: the tag store must accept one index per cycle while `line_clr_valid` is high.

Top module: `cache_ctl_mon`

## Requirements
- R1: After reset, all eight counters read 0 and no sweep runs, so `inval_busy` and `line_clr_valid` are 0.
- R2: `cache_ready` is 1 exactly when `cache_en` is 1 and `inval_busy` is 0.
- R3: A strobe on `inval_wr` in cycle t starts a sweep. In cycles t+1 through t+LINES, `line_clr_valid` is 1 and `line_clr_idx` counts 0, 1, …, LINES-1. In cycle t+LINES+1 the sweep has ended.
- R4: A strobe on `inval_wr` during a sweep restarts it. In the next cycle `line_clr_idx` is 0, followed by a full LINES-cycle sweep.
- R5: While `mon_en` is 1, each counter adds one on every cycle in which its event bit is 1. Bit k of `dmon_evt` drives data counter k, and bit k of `imon_evt` drives instruction counter k.
- R6: While `mon_en` is 0, event pulses have no effect and every counter keeps its value.
- R7: A strobe on `stat_clr_wr` sets all eight counters to 0 in the next cycle, whatever `mon_en` is.
- R8: When a clear strobe and a counted event fall in the same cycle, the clear wins and the counter becomes 0.
- R9: A counter at its all-ones value stays there on further events and never wraps.
- R10: Counter k occupies bits [k*CNT_W +: CNT_W] of `dmon_cnt` and `imon_cnt`. An event on one counter leaves every other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enabled by configuration |
| mon_en | input | 1 | Monitoring enabled; when 0, counters hold |
| inval_wr | input | 1 | One-cycle invalidate strobe |
| stat_clr_wr | input | 1 | One-cycle statistics-clear strobe |
| dmon_evt | input | NUM_MON | Data-side event pulses |
| imon_evt | input | NUM_MON | Instruction-side event pulses |
| cache_ready | output | 1 | Enabled and not invalidating |
| inval_busy | output | 1 | Sweep in progress |
| line_clr_valid | output | 1 | Line index on the clear port is valid this cycle |
| line_clr_idx | output | IDX_W | Index of the line to clear |
| dmon_cnt | output | NUM_MON*CNT_W | Data-side counters, packed |
| imon_cnt | output | NUM_MON*CNT_W | Instruction-side counters, packed |

## Verification
The hardest case to reach from the ports is saturation. With the default 32-bit counters it would take billions of events, so the bench builds a 4-bit counter configuration. In that configuration, all 256 patterns on the eight event bits drive every counter past its limit within a few hundred cycles. The bench models each counter arithmetically after every pattern. Restarting a sweep also needs exact timing: the second strobe arrives while `line_clr_idx` is mid-sweep, and the bench then checks that the index sequence begins again from 0.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
  localparam int NUM_MON = 4;

  typedef enum logic { SW_IDLE = 1'b0, SW_RUN = 1'b1 } sweep_state_t;
endpackage

// File: rtl/cache_inval_seq.sv
module cache_inval_seq
  import cache_ctl_pkg::*;
#(
  parameter int LINES = 256,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  sweep_state_t     state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      idx_q   <= '0;
    end else if (start) begin
      state_q <= SW_RUN;
      idx_q   <= '0;
    end else if (state_q == SW_RUN) begin
      if (idx_q == LAST_IDX) begin
        state_q <= SW_IDLE;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy = (state_q == SW_RUN);
  assign idx  = idx_q;
endmodule

// File: rtl/cache_evt_counter.sv
module cache_evt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             evt,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic             bump;

  assign bump = en && evt && (count_q != CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)    count_q <= '0;
    else if (clr)  count_q <= '0;
    else if (bump) count_q <= count_q + 1'b1;
  end

  assign count = count_q;
endmodule

// File: rtl/cache_mon_bank.sv
module cache_mon_bank
  import cache_ctl_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NUM   = NUM_MON,
  localparam int BUS_W = NUM * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [NUM-1:0]   evt,
  output logic [BUS_W-1:0] counts
);
  for (genvar k = 0; k < NUM; k++) begin : g_cnt
    cache_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (en),
      .evt   (evt[k]),
      .count (counts[k*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/cache_ctl_mon.sv
module cache_ctl_mon
  import cache_ctl_pkg::*;
#(
  parameter int LINES = 256,
  parameter int CNT_W = 32,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BUS_W = NUM_MON * CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cache_en,
  input  logic               mon_en,
  input  logic               inval_wr,
  input  logic               stat_clr_wr,
  input  logic [NUM_MON-1:0] dmon_evt,
  input  logic [NUM_MON-1:0] imon_evt,
  output logic               cache_ready,
  output logic               inval_busy,
  output logic               line_clr_valid,
  output logic [IDX_W-1:0]   line_clr_idx,
  output logic [BUS_W-1:0]   dmon_cnt,
  output logic [BUS_W-1:0]   imon_cnt
);
  logic sweep_busy;

  cache_inval_seq #(.LINES(LINES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (inval_wr),
    .busy  (sweep_busy),
    .idx   (line_clr_idx)
  );

  cache_mon_bank #(.CNT_W(CNT_W), .NUM(NUM_MON)) u_dmon (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (stat_clr_wr),
    .en     (mon_en),
    .evt    (dmon_evt),
    .counts (dmon_cnt)
  );

  cache_mon_bank #(.CNT_W(CNT_W), .NUM(NUM_MON)) u_imon (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (stat_clr_wr),
    .en     (mon_en),
    .evt    (imon_evt),
    .counts (imon_cnt)
  );

  assign inval_busy     = sweep_busy;
  assign line_clr_valid = sweep_busy;
  assign cache_ready    = cache_en && !sweep_busy;
endmodule

// File: rtl/cache_ctl_mon_chk.sv
module cache_ctl_mon_chk
  import cache_ctl_pkg::*;
#(
  parameter int LINES = 256,
  parameter int CNT_W = 32,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BUS_W = NUM_MON * CNT_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cache_en,
  input logic               mon_en,
  input logic               inval_wr,
  input logic               stat_clr_wr,
  input logic [NUM_MON-1:0] dmon_evt,
  input logic [NUM_MON-1:0] imon_evt,
  input logic               cache_ready,
  input logic               inval_busy,
  input logic               line_clr_valid,
  input logic [IDX_W-1:0]   line_clr_idx,
  input logic [BUS_W-1:0]   dmon_cnt,
  input logic [BUS_W-1:0]   imon_cnt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    inval_busy |-> !cache_ready); // R2

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_clr_valid && !inval_wr && line_clr_idx != LAST_IDX) |=>
      (line_clr_valid && line_clr_idx == IDX_W'($past(line_clr_idx) + 1'b1))); // R3

  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (line_clr_valid && !inval_wr && line_clr_idx == LAST_IDX) |=> !line_clr_valid); // R3

  AST_SWEEP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    inval_wr |=> (line_clr_valid && line_clr_idx == '0)); // R4

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !stat_clr_wr) |=> ($stable(dmon_cnt) && $stable(imon_cnt))); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_wr |=> (dmon_cnt == '0 && imon_cnt == '0)); // R8

  for (genvar k = 0; k < NUM_MON; k++) begin : g_sat
    AST_NO_WRAP_D: assert property (@(posedge clk) disable iff (!rst_n)
      (dmon_cnt[k*CNT_W +: CNT_W] == CNT_MAX && !stat_clr_wr) |=>
        (dmon_cnt[k*CNT_W +: CNT_W] == CNT_MAX)); // R9
    AST_NO_WRAP_I: assert property (@(posedge clk) disable iff (!rst_n)
      (imon_cnt[k*CNT_W +: CNT_W] == CNT_MAX && !stat_clr_wr) |=>
        (imon_cnt[k*CNT_W +: CNT_W] == CNT_MAX)); // R9
  end
endmodule

bind cache_ctl_mon cache_ctl_mon_chk #(.LINES(LINES), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/cache_ctl_mon_test.sv
module cache_ctl_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int CNT_W = 4;
  localparam int NM    = 4;
  localparam int IDX_W = $clog2(LINES);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_en = 1'b0, mon_en = 1'b0, inval_wr = 1'b0, stat_clr_wr = 1'b0;
  logic [NM-1:0] dmon_evt = '0, imon_evt = '0;
  logic cache_ready, inval_busy, line_clr_valid;
  logic [IDX_W-1:0] line_clr_idx;
  logic [NM*CNT_W-1:0] dmon_cnt, imon_cnt;

  int tests = 0;
  int fails = 0;
  int exp_cnt [2*NM];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_ctl_mon #(.LINES(LINES), .CNT_W(CNT_W)) uut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int cnt_of(input int k);
    if (k < NM) return int'(dmon_cnt[k*CNT_W +: CNT_W]);
    return int'(imon_cnt[(k-NM)*CNT_W +: CNT_W]);
  endfunction

  task automatic chk_counters(input string req);
    for (int k = 0; k < 2*NM; k++)
      chk(cnt_of(k) == exp_cnt[k], req, cnt_of(k), exp_cnt[k]);
  endtask

  task automatic chk_sweep(input string req);
    for (int i = 0; i < LINES; i++) begin
      chk(line_clr_valid && int'(line_clr_idx) == i, req, int'(line_clr_idx), i);
      chk(!cache_ready && inval_busy, "R2", int'(cache_ready), 0);
      tick();
    end
    chk(!line_clr_valid && !inval_busy, req, int'(line_clr_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2*NM; k++) exp_cnt[k] = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk_counters("R1");
    chk(!inval_busy && !line_clr_valid, "R1", int'(inval_busy), 0);
    // R2 ready follows enable
    chk(!cache_ready, "R2", int'(cache_ready), 0);
    cache_en = 1'b1;
    #1;
    chk(cache_ready, "R2", int'(cache_ready), 1);

    // R3 full sweep
    inval_wr = 1'b1;
    tick();
    inval_wr = 1'b0;
    chk_sweep("R3");
    chk(cache_ready, "R2", int'(cache_ready), 1);

    // R4 restart mid-sweep
    inval_wr = 1'b1;
    tick();
    inval_wr = 1'b0;
    tick();
    tick();
    chk(int'(line_clr_idx) == 2, "R4", int'(line_clr_idx), 2);
    inval_wr = 1'b1;
    tick();
    inval_wr = 1'b0;
    chk_sweep("R4");

    // R5 R9 R10 all event patterns with monitoring on
    mon_en = 1'b1;
    for (int p = 0; p < 256; p++) begin
      {imon_evt, dmon_evt} = 8'(p);
      tick();
      for (int k = 0; k < 2*NM; k++)
        if (p[k] && exp_cnt[k] < CMAX) exp_cnt[k]++;
      chk_counters("R5_R9_R10");
    end
    dmon_evt = '0; imon_evt = '0;
    for (int k = 0; k < 2*NM; k++)
      chk(cnt_of(k) == CMAX, "R9", cnt_of(k), CMAX);

    // R7 clear, then single-counter independence R10
    stat_clr_wr = 1'b1;
    tick();
    stat_clr_wr = 1'b0;
    for (int k = 0; k < 2*NM; k++) exp_cnt[k] = 0;
    chk_counters("R7");
    for (int k = 0; k < 2*NM; k++) begin
      {imon_evt, dmon_evt} = 8'(1 << k);
      repeat (k + 1) tick();
      exp_cnt[k] = k + 1;
      chk_counters("R10");
    end
    dmon_evt = '0; imon_evt = '0;

    // R6 pause holds under all patterns
    mon_en = 1'b0;
    for (int p = 0; p < 256; p++) begin
      {imon_evt, dmon_evt} = 8'(p);
      tick();
    end
    chk_counters("R6");

    // R8 clear with events present and monitoring on
    mon_en = 1'b1;
    {imon_evt, dmon_evt} = 8'hFF;
    stat_clr_wr = 1'b1;
    tick();
    stat_clr_wr = 1'b0;
    dmon_evt = '0; imon_evt = '0;
    for (int k = 0; k < 2*NM; k++) exp_cnt[k] = 0;
    chk_counters("R8");

    // R7 clear while paused
    {imon_evt, dmon_evt} = 8'h81;
    tick();
    mon_en = 1'b0;
    dmon_evt = '0; imon_evt = '0;
    stat_clr_wr = 1'b1;
    tick();
    stat_clr_wr = 1'b0;
    chk_counters("R7");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule